// File: doc/BRIEF.md
# Two-stage serial clock rate generator

This block produces the serial clock that a synchronous serial port master drives onto its clock pin. The system clock is divided in two cascaded stages: an even prescaler (2 to 254) followed by a post-divider of 1 to 256 set by an 8-bit rate field. The serial clock period is the product of the two divisors. Because that product is always even, the output has an exact 50% duty cycle.

Alongside the serial clock, the block emits two single-cycle strobes, one for the leading edge (leaving the idle level) and one for the trailing edge (returning to it). Shift logic uses them to launch and capture data. While the enable is low the clock rests at a selectable idle level. New divisor settings never disturb a period that is already running.

Top module: `sclk_rate_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sclk` is 0 and both strobes are 0.
- R2: The effective prescale value P is `prescale_in` with bit 0 forced to 0. A result of 0 is treated as 2, so inputs 0, 1, 2 and 3 all give P = 2.
- R3: While enabled, `sclk` changes level every P*(1+`rate_in`)/2 system clock cycles. The full period is P*(1+`rate_in`) cycles with equal high and low time.
- R4: The rate field covers divisors 1 to 256. With P = 2, rate 0 gives a toggle every cycle (total division 2), and rate 255 gives a toggle every 256 cycles.
- R5: After `en` is first sampled high, the first `sclk` change comes after one full half-period, counting that edge as the first, and it is a leading edge.
- R6: `lead_stb` is high for exactly the cycle in which `sclk` first shows the non-idle level. `trail_stb` is high for exactly the cycle in which it first shows the idle level again. The two are never high together.
- R7: One cycle after `en` is sampled low, `sclk` equals the `idle_hi` value sampled at that edge. No strobe is produced, and the counters restart from zero.
- R8: `prescale_in` and `rate_in` take effect only when disabled or at a trailing edge, so a running period keeps its length. `idle_hi` changes made while enabled have no effect until `en` is low.
- R9: Dropping `en` in mid-period returns `sclk` to idle without a strobe. Re-enabling waits a full half-period before the next leading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the divider at rest |
| idle_hi | input | 1 | Idle level of the serial clock (1 = high) |
| prescale_in | input | 8 | First-stage divisor, even 2 to 254 |
| rate_in | input | 8 | Second-stage divisor minus one |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the leading edge |
| trail_stb | output | 1 | One-cycle strobe on the trailing edge |

## Verification
The hardest case to reach is a divisor or polarity change that arrives partway through a running period. The new value must be held back until the next trailing edge, and the polarity until the block is disabled. The stimulus reaches this by writing new settings a few cycles into a short period and flipping `idle_hi` while the clock runs. It also drops `en` mid-period and re-enables at once. The reference model in the bench samples settings only at those same boundaries, so any early or late adoption shows up as a cycle mismatch.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } sclk_phase_e;
endpackage

// File: rtl/sclk_cfg_shadow.sv
module sclk_cfg_shadow #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8,
  localparam int HP_W  = PRE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_div,
  input  logic              load_pol,
  input  logic              idle_hi,
  input  logic [PRE_W-1:0]  prescale_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic [HP_W-1:0]   half_pre_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              pol_q
);
  logic [HP_W-1:0] half_pre_n;

  // Halved prescale: drop bit 0, clamp to at least one (P >= 2).
  always_comb begin
    half_pre_n = prescale_in[PRE_W-1:1];
    if (half_pre_n == '0) half_pre_n = HP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || load_div) begin
      half_pre_q <= half_pre_n;
      rate_q     <= rate_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           pol_q <= 1'b0;
    else if (load_pol) pol_q <= idle_hi;
  end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int HP_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HP_W-1:0] half_pre,
  output logic            tick
);
  logic [HP_W-1:0] cnt_q;
  logic            at_end;

  assign at_end = (cnt_q == half_pre - HP_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + HP_W'(1);
  end
endmodule

// File: rtl/sclk_rate_div.sv
module sclk_rate_div #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              toggle
);
  logic [RATE_W-1:0] cnt_q;
  logic              at_end;

  assign at_end = (cnt_q == rate);
  assign toggle = tick && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (toggle)  cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + RATE_W'(1);
  end
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              idle_hi,
  input  logic [PRE_W-1:0]  prescale_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);
  import sclk_pkg::*;
  localparam int HP_W = PRE_W - 1;

  logic [HP_W-1:0]   half_pre_act;
  logic [RATE_W-1:0] rate_act;
  logic              pol_act;
  logic              pre_tick;
  logic              toggle;
  logic              trail_now;
  sclk_phase_e       phase_q;

  assign trail_now = toggle && (phase_q == PH_ACTIVE);

  sclk_cfg_shadow #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load_div   (!en || trail_now),
    .load_pol   (!en),
    .idle_hi    (idle_hi),
    .prescale_in(prescale_in),
    .rate_in    (rate_in),
    .half_pre_q (half_pre_act),
    .rate_q     (rate_act),
    .pol_q      (pol_act)
  );

  sclk_prescaler #(.HP_W(HP_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .half_pre(half_pre_act),
    .tick    (pre_tick)
  );

  sclk_rate_div #(.RATE_W(RATE_W)) u_rate (
    .clk   (clk),
    .rst   (rst),
    .run   (en),
    .tick  (pre_tick),
    .rate  (rate_act),
    .toggle(toggle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      sclk      <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!en) begin
      phase_q   <= PH_IDLE;
      sclk      <= idle_hi;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= toggle && (phase_q == PH_IDLE);
      trail_stb <= trail_now;
      if (toggle) begin
        sclk    <= ~sclk;
        phase_q <= (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
  parameter int HP_W   = 7,
  parameter int RATE_W = 8,
  localparam int CW    = HP_W + RATE_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              idle_hi,
  input logic              sclk,
  input logic              lead_stb,
  input logic              trail_stb,
  input logic              pol_act,
  input logic              toggle,
  input logic [HP_W-1:0]   half_pre_act,
  input logic [RATE_W-1:0] rate_act
);
  logic [CW-1:0] since_q;
  logic [CW-1:0] target;

  assign target = CW'(half_pre_act) * (CW'(rate_act) + CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en || toggle) since_q <= '0;
    else                      since_q <= since_q + CW'(1);
  end

  assert_half_period_R3: assert property (@(posedge clk) disable iff (rst)
    toggle |-> (since_q + CW'(1) == target));

  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb));

  assert_strobe_marks_change_R6: assert property (@(posedge clk) disable iff (rst)
    (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

  assert_lead_leaves_idle_R6: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> (sclk != pol_act));

  assert_trail_returns_idle_R6: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> (sclk == pol_act));

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!lead_stb && !trail_stb && sclk == $past(idle_hi)));

  assert_no_silent_change_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !lead_stb && !trail_stb) |-> $stable(sclk));
endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.HP_W(PRE_W - 1), .RATE_W(RATE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .idle_hi     (idle_hi),
  .sclk        (sclk),
  .lead_stb    (lead_stb),
  .trail_stb   (trail_stb),
  .pol_act     (pol_act),
  .toggle      (toggle),
  .half_pre_act(half_pre_act),
  .rate_act    (rate_act)
);

// File: tb/tb_sclk_rate_gen.sv
module tb_sclk_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       idle_hi = 1'b0;
  logic [7:0] prescale_in = 8'd2;
  logic [7:0] rate_in = 8'd0;
  logic       sclk, lead_stb, trail_stb;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state
  int m_half, m_cnt;
  bit m_sclk, m_lead, m_trail, m_active;

  always #4 clk = ~clk;

  sclk_rate_gen dut (
    .clk(clk), .rst(rst), .en(en), .idle_hi(idle_hi),
    .prescale_in(prescale_in), .rate_in(rate_in),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  function automatic int half_of(input int p, input int r);
    int pe;
    pe = p - (p % 2);
    if (pe < 2) pe = 2;
    return pe * (r + 1) / 2;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_sclk = 0; m_lead = 0; m_trail = 0; m_cnt = 0; m_active = 0;
      m_half = half_of(prescale_in, rate_in);
    end else if (!en) begin
      m_sclk = idle_hi; m_lead = 0; m_trail = 0; m_cnt = 0; m_active = 0;
      m_half = half_of(prescale_in, rate_in);
    end else begin
      m_lead = 0; m_trail = 0;
      m_cnt++;
      if (m_cnt == m_half) begin
        m_cnt  = 0;
        m_sclk = !m_sclk;
        if (m_active) begin
          m_trail = 1;
          m_half  = half_of(prescale_in, rate_in);
        end else begin
          m_lead = 1;
        end
        m_active = !m_active;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (sclk !== m_sclk || lead_stb !== m_lead || trail_stb !== m_trail) begin
        n_bad++;
        $display("FAIL %s t=%0t actual sclk/lead/trail=%b%b%b expected=%b%b%b",
                 tag, $time, sclk, lead_stb, trail_stb, m_sclk, m_lead, m_trail);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    tag = "R1"; step(4);
    rst = 1'b0; step(3);
    // R7: disabled, idle high then low
    tag = "R7"; idle_hi = 1'b1; step(6);
    idle_hi = 1'b0; step(4);
    // R5, R3, R6: P=6, rate 3 -> half period 12
    tag = "R5"; prescale_in = 8'd6; rate_in = 8'd3; en = 1'b1; step(13);
    tag = "R3"; step(90);
    // R2: odd prescale 7 acts as 6; rate 2
    tag = "R2"; en = 1'b0; step(2);
    prescale_in = 8'd7; rate_in = 8'd2; en = 1'b1; step(60);
    en = 1'b0; prescale_in = 8'd0; rate_in = 8'd0; step(2);
    en = 1'b1; step(12);
    en = 1'b0; prescale_in = 8'd1; rate_in = 8'd4; step(2);
    en = 1'b1; step(30);
    en = 1'b0; prescale_in = 8'd3; rate_in = 8'd1; step(2);
    en = 1'b1; step(12);
    // R4: extremes of rate stage
    tag = "R4"; en = 1'b0; prescale_in = 8'd2; rate_in = 8'd255; step(2);
    en = 1'b1; step(1100);
    en = 1'b0; rate_in = 8'd0; step(2);
    en = 1'b1; step(20);
    en = 1'b0; prescale_in = 8'd254; step(2);
    en = 1'b1; step(600);
    // R8: mid-period config change and polarity flip while running
    tag = "R8"; en = 1'b0; prescale_in = 8'd4; rate_in = 8'd1; idle_hi = 1'b1; step(2);
    en = 1'b1; step(3);
    prescale_in = 8'd10; rate_in = 8'd2; step(7);
    prescale_in = 8'd2; rate_in = 8'd0; step(60);
    idle_hi = 1'b0; step(25);
    en = 1'b0; step(4);
    // R6: strobes under polarity low, short period
    tag = "R6"; prescale_in = 8'd4; rate_in = 8'd0; en = 1'b1; step(40);
    // R9: drop enable mid-period and restart
    tag = "R9"; en = 1'b0; step(1);
    en = 1'b1; step(1);
    en = 1'b0; step(3);
    idle_hi = 1'b1; prescale_in = 8'd8; rate_in = 8'd1; step(1);
    en = 1'b1; step(5);
    en = 1'b0; step(1);
    en = 1'b1; step(40);
    en = 1'b0; step(5);
    finish_run();
  end
endmodule